// File: doc/BRIEF.md
# Programmable External Bus Strobe Timer

This block drives the control strobes of one external memory region. Each access is a bus cycle, counted in memory-clock periods from the cycle start. During the cycle the block drives an address strobe, a read strobe and a write strobe, all active low, together with an address-valid window. A 16-bit configuration word places the address-strobe edges and the negate point of the read/write strobes. The read/write assert point and the cycle end are fixed by parameters.

The CPU side starts a cycle through a valid/ready request channel. Completion is signalled by a one-clock `done` pulse. The request channel applies back-pressure by holding `req_ready` low while a cycle runs, and also while a configuration write captured during a cycle is still waiting to be applied. A requester may hold `req_valid` high for as long as it likes. The request is taken only on an edge where `req_valid` and `req_ready` are both high. `req_write` is sampled on that same edge.

A configuration word whose fields break the ordering rules is not applied. The block keeps the previous setting and raises a sticky error flag. The block has one clock, which is taken as the memory clock. When the mode bit selects synchronous operation, a cycle shrinks to a single clock.

Top module: `ext_strobe_timer`

## Requirements
- R1: After reset, `cfg_rd_data` reads 16'hEB40 (synchronous mode, address strobe from count 1 to 3, read/write negate at 29). In the same state all strobes are high, `addr_valid`, `done` and `cfg_err` are low, and `req_ready` is high.
- R2: The configuration word layout is fixed as follows. Bits 15:11 hold the read/write negate count. Bits 10:8 hold the address-strobe negate count. Bits 7:6 hold the address-strobe assert count. Bit 2 is the mode, where 1 means asynchronous. Bits 5:3 and 1:0 read back as zero, so writing 16'hFFFF reads back 16'hFFC4.
- R3: A request is accepted on a rising edge with `req_valid` and `req_ready` both high. `req_ready` is low for the whole cycle, and any `req_valid` seen while it is low is ignored.
- R4: In asynchronous mode the count is 0 in the clock after acceptance and rises by one every clock. `done` is high only at count 31. The block is idle in the next clock.
- R5: In asynchronous mode `as_n` is low exactly for counts c with asa <= c < asn.
- R6: In asynchronous mode the direction strobe is low exactly for counts 3 <= c < wen. That strobe is `we_n` when `req_write` was 1 at acceptance, and `re_n` otherwise. The other strobe stays high.
- R7: `addr_valid` is high for every count of an active cycle and low when idle. No strobe is low outside it.
- R8: In synchronous mode (bit 2 = 0) a cycle lasts one clock. In that clock `as_n`, the direction strobe, `addr_valid` and `done` are all active.
- R9: A write whose fields give asn <= asa, or wen <= 3, is rejected. The active configuration is unchanged and `cfg_err` goes high and stays high until reset. Later legal writes still apply.
- R10: A write during an active cycle is held and applied in the second clock after `done`. A later held write replaces an earlier one. `req_ready` stays low until the held write is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 16 | Configuration word to write |
| cfg_rd_data | output | 16 | Active configuration, reserved bits zero |
| cfg_err | output | 1 | Sticky flag for a rejected configuration |
| req_valid | input | 1 | Bus cycle request valid |
| req_write | input | 1 | Direction of the request, 1 = write |
| req_ready | output | 1 | Block can accept a request |
| done | output | 1 | One-clock pulse at the last count of a cycle |
| as_n | output | 1 | Address strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| addr_valid | output | 1 | Address window of the active cycle |

## Verification
The bench builds the block with its default parameters: a cycle end at count 31 and a strobe assert point at count 3. With these values every count of every cycle can be sampled and compared against an independent window model. That includes the extreme settings (negate at 31, address strobe spanning 3 to 7) and the narrowest legal windows (a one-count address strobe and a one-count direction strobe). The defaults also allow held writes to be issued mid-cycle, at known counts, in a cycle long enough to observe the pending state. Synchronous mode comes straight out of reset, so the single-clock cycle is checked before any write.

// File: rtl/esbt_pkg.sv
package esbt_pkg;

  // Field layout of the configuration word (software-visible, so fixed)
  localparam int WEN_HI = 15;
  localparam int WEN_LO = 11;
  localparam int ASN_HI = 10;
  localparam int ASN_LO = 8;
  localparam int ASA_HI = 7;
  localparam int ASA_LO = 6;
  localparam int MODE_BIT = 2;

  typedef struct packed {
    logic [4:0] wen;       // read/write negate count
    logic [2:0] asn;       // address strobe negate count
    logic [1:0] asa;       // address strobe assert count
    logic       async_md;  // 1: counted asynchronous cycle
  } esbt_cfg_t;

  function automatic logic [15:0] pack_cfg(input esbt_cfg_t c);
    return {c.wen, c.asn, c.asa, 3'b000, c.async_md, 2'b00};
  endfunction

  function automatic logic cfg_legal(input esbt_cfg_t c, input logic [4:0] ea);
    return (c.asn > {1'b0, c.asa}) && (c.wen > ea);
  endfunction

endpackage

// File: rtl/esbt_cfg_reg.sv
module esbt_cfg_reg
  import esbt_pkg::*;
#(
  parameter int          EA_PT   = 3,
  parameter logic [15:0] RST_CFG = 16'hEB40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [15:0] wr_data,
  input  logic       seq_busy,
  output esbt_cfg_t  cfg,
  output logic       pend_v,
  output logic       err
);

  localparam esbt_cfg_t RST_VAL = '{wen: RST_CFG[WEN_HI:WEN_LO],
                                    asn: RST_CFG[ASN_HI:ASN_LO],
                                    asa: RST_CFG[ASA_HI:ASA_LO],
                                    async_md: RST_CFG[MODE_BIT]};

  esbt_cfg_t cur_q, pend_q, wr_cfg, app_val;
  logic      app_go, app_ok;
  logic      unused_rsvd;

  assign wr_cfg = '{wen: wr_data[WEN_HI:WEN_LO],
                    asn: wr_data[ASN_HI:ASN_LO],
                    asa: wr_data[ASA_HI:ASA_LO],
                    async_md: wr_data[MODE_BIT]};
  assign unused_rsvd = ^{wr_data[5:3], wr_data[1:0]};

  always_comb begin
    app_go  = !seq_busy && (wr_en || pend_v);
    app_val = wr_en ? wr_cfg : pend_q;
    app_ok  = cfg_legal(app_val, 5'(EA_PT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= RST_VAL;
      pend_q <= '0;
      pend_v <= 1'b0;
      err    <= 1'b0;
    end else if (wr_en && seq_busy) begin
      pend_q <= wr_cfg;
      pend_v <= 1'b1;
    end else if (app_go) begin
      pend_v <= 1'b0;
      if (app_ok) cur_q <= app_val;
      else        err   <= 1'b1;
    end
  end

  assign cfg = cur_q;

endmodule

// File: rtl/esbt_seq.sv
module esbt_seq #(
  parameter int END_PT = 31,
  parameter int CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_write,
  input  logic             sync_md,
  output logic             busy,
  output logic [CNT_W-1:0] cnt,
  output logic             is_write,
  output logic             done
);

  logic [CNT_W-1:0] end_cnt;

  assign end_cnt = sync_md ? '0 : CNT_W'(END_PT);
  assign done    = busy && (cnt == end_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      is_write <= 1'b0;
    end else if (start) begin
      busy     <= 1'b1;
      cnt      <= '0;
      is_write <= start_write;
    end else if (busy) begin
      if (done) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/esbt_strobe.sv
module esbt_strobe
  import esbt_pkg::*;
#(
  parameter int EA_PT = 3,
  parameter int CNT_W = 5
) (
  input  logic             busy,
  input  logic [CNT_W-1:0] cnt,
  input  logic             is_write,
  input  esbt_cfg_t        cfg,
  output logic             as_n,
  output logic             re_n,
  output logic             we_n,
  output logic             addr_valid
);

  logic       as_on, rw_on;
  logic [1:0] dir_n;  // [0] read, [1] write

  always_comb begin
    if (!cfg.async_md) begin
      as_on = busy;
      rw_on = busy;
    end else begin
      as_on = busy && (cnt >= CNT_W'(cfg.asa)) && (cnt < CNT_W'(cfg.asn));
      rw_on = busy && (cnt >= CNT_W'(EA_PT)) && (cnt < CNT_W'(cfg.wen));
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_dir
    assign dir_n[g] = !(rw_on && (is_write == (g == 1)));
  end

  assign as_n       = !as_on;
  assign re_n       = dir_n[0];
  assign we_n       = dir_n[1];
  assign addr_valid = busy;

endmodule

// File: rtl/ext_strobe_timer.sv
module ext_strobe_timer
  import esbt_pkg::*;
#(
  parameter int          END_PT  = 31,
  parameter int          EA_PT   = 3,
  parameter logic [15:0] RST_CFG = 16'hEB40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr_en,
  input  logic [15:0] cfg_wr_data,
  output logic [15:0] cfg_rd_data,
  output logic        cfg_err,
  input  logic        req_valid,
  input  logic        req_write,
  output logic        req_ready,
  output logic        done,
  output logic        as_n,
  output logic        re_n,
  output logic        we_n,
  output logic        addr_valid
);

  localparam int CNT_W = $clog2(END_PT + 1);

  esbt_cfg_t        cfg;
  logic             pend_v, busy, is_write, start;
  logic [CNT_W-1:0] cnt;

  assign req_ready   = !busy && !pend_v;
  assign start       = req_valid && req_ready;
  assign cfg_rd_data = pack_cfg(cfg);

  esbt_cfg_reg #(.EA_PT(EA_PT), .RST_CFG(RST_CFG)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .seq_busy(busy), .cfg(cfg), .pend_v(pend_v), .err(cfg_err)
  );

  esbt_seq #(.END_PT(END_PT), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_write(req_write),
    .sync_md(!cfg.async_md), .busy(busy), .cnt(cnt),
    .is_write(is_write), .done(done)
  );

  esbt_strobe #(.EA_PT(EA_PT), .CNT_W(CNT_W)) u_stb (
    .busy(busy), .cnt(cnt), .is_write(is_write), .cfg(cfg),
    .as_n(as_n), .re_n(re_n), .we_n(we_n), .addr_valid(addr_valid)
  );

endmodule

// File: rtl/esbt_checker.sv
module esbt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        done,
  input logic        as_n,
  input logic        re_n,
  input logic        we_n,
  input logic        addr_valid,
  input logic [15:0] cfg_rd_data,
  input logic        cfg_err
);

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_data & 16'h003B) == 16'h0000);

  p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> addr_valid);

  p_busy_notready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> !req_ready);

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_in_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> addr_valid);

  p_one_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> (re_n || we_n));

  p_strobe_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n || !re_n || !we_n) |-> addr_valid);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && $past(addr_valid)) |-> $stable(cfg_rd_data));

endmodule

bind ext_strobe_timer esbt_checker i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .as_n(as_n), .re_n(re_n), .we_n(we_n),
  .addr_valid(addr_valid), .cfg_rd_data(cfg_rd_data), .cfg_err(cfg_err)
);

// File: tb/test_ext_strobe_timer.sv
module test_ext_strobe_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [15:0] cfg_wr_data = '0;
  logic [15:0] cfg_rd_data;
  logic        cfg_err;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic        req_ready, done, as_n, re_n, we_n, addr_valid;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  ext_strobe_timer i_ext_strobe_timer (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .cfg_err(cfg_err), .req_valid(req_valid),
    .req_write(req_write), .req_ready(req_ready), .done(done), .as_n(as_n),
    .re_n(re_n), .we_n(we_n), .addr_valid(addr_valid)
  );

  function automatic logic [15:0] mk(input logic bm, input int asa, input int asn, input int wen);
    return {5'(wen), 3'(asn), 2'(asa), 3'b000, bm, 2'b00};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [15:0] d);
    @(negedge clk);
    cfg_wr_en   = 1'b1;
    cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en   = 1'b0;
  endtask

  // Sample count 0..31 of an async cycle already accepted; expects window model
  task automatic watch_cycle(input int asa, input int asn, input int wen, input logic wr);
    for (int k = 0; k <= 31; k++) begin
      if (k > 0) @(negedge clk);
      chk("R5", $sformatf("as_n@%0d", k), 16'(as_n), 16'(!(k >= asa && k < asn)));
      chk("R6", $sformatf("re_n@%0d", k), 16'(re_n), 16'(!(!wr && k >= 3 && k < wen)));
      chk("R6", $sformatf("we_n@%0d", k), 16'(we_n), 16'(!(wr && k >= 3 && k < wen)));
      chk("R7", $sformatf("addr_valid@%0d", k), 16'(addr_valid), 16'd1);
      chk("R4", $sformatf("done@%0d", k), 16'(done), 16'(k == 31));
      chk("R3", $sformatf("ready@%0d", k), 16'(req_ready), 16'd0);
    end
    @(negedge clk);
    chk("R4", "idle after end", 16'(addr_valid), 16'd0);
    chk("R7", "strobes idle", 16'({as_n, re_n, we_n}), 16'h7);
    chk("R4", "done cleared", 16'(done), 16'd0);
  endtask

  task automatic t_reset;
    chk("R1", "cfg", cfg_rd_data, 16'hEB40);
    chk("R1", "strobes", 16'({as_n, re_n, we_n}), 16'h7);
    chk("R1", "addr_valid", 16'(addr_valid), 16'd0);
    chk("R1", "done", 16'(done), 16'd0);
    chk("R1", "err", 16'(cfg_err), 16'd0);
    chk("R1", "ready", 16'(req_ready), 16'd1);
  endtask

  task automatic t_sync;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8", "as_n", 16'(as_n), 16'd0);
    chk("R8", "re_n", 16'(re_n), 16'd0);
    chk("R8", "we_n", 16'(we_n), 16'd1);
    chk("R8", "addr_valid", 16'(addr_valid), 16'd1);
    chk("R8", "done", 16'(done), 16'd1);
    @(negedge clk);
    chk("R8", "idle", 16'({addr_valid, done}), 16'd0);
    chk("R8", "ready", 16'(req_ready), 16'd1);
    req_valid = 1'b1; req_write = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8", "we_n write", 16'({we_n, re_n}), 16'b01);
  endtask

  task automatic t_readback;
    cfg_write(16'hFFFF);
    chk("R2", "reserved bits", cfg_rd_data, 16'hFFC4);
  endtask

  task automatic t_async(input int asa, input int asn, input int wen, input logic wr);
    cfg_write(mk(1'b1, asa, asn, wen));
    chk("R2", "field layout", cfg_rd_data, mk(1'b1, asa, asn, wen));
    chk("R3", "ready idle", 16'(req_ready), 16'd1);
    req_valid = 1'b1; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    watch_cycle(asa, asn, wen, wr);
  endtask

  task automatic t_ignored_req;
    cfg_write(mk(1'b1, 1, 3, 29));
    req_valid = 1'b1; req_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 1; k <= 31; k++) begin
      @(negedge clk);
      if (k == 10) req_valid = 1'b1;
      if (k == 31) begin
        chk("R3", "ready low at end", 16'(req_ready), 16'd0);
        req_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk("R3", "busy request ignored", 16'(addr_valid), 16'd0);
    chk("R3", "ready back", 16'(req_ready), 16'd1);
  endtask

  task automatic t_held_write;
    logic [15:0] c0, cb;
    c0 = mk(1'b1, 1, 3, 29);
    cb = mk(1'b1, 2, 5, 20);
    cfg_write(c0);
    req_valid = 1'b1; req_write = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 1; k <= 31; k++) begin
      @(negedge clk);
      cfg_wr_en = 1'b0;
      if (k == 5) begin cfg_wr_en = 1'b1; cfg_wr_data = mk(1'b1, 0, 2, 10); end
      if (k == 6) begin cfg_wr_en = 1'b1; cfg_wr_data = cb; end
      if (k == 10) begin
        chk("R10", "cfg held mid-cycle", cfg_rd_data, c0);
        chk("R10", "ready low mid-cycle", 16'(req_ready), 16'd0);
      end
    end
    @(negedge clk);
    chk("R10", "idle, pending", 16'(addr_valid), 16'd0);
    chk("R10", "ready low while pending", 16'(req_ready), 16'd0);
    chk("R10", "cfg not yet applied", cfg_rd_data, c0);
    @(negedge clk);
    chk("R10", "latest write applied", cfg_rd_data, cb);
    chk("R10", "ready after apply", 16'(req_ready), 16'd1);
  endtask

  task automatic t_illegal;
    logic [15:0] prev;
    prev = cfg_rd_data;
    chk("R9", "err clear", 16'(cfg_err), 16'd0);
    cfg_write(mk(1'b1, 2, 2, 20));
    chk("R9", "asn==asa err", 16'(cfg_err), 16'd1);
    chk("R9", "asn==asa kept", cfg_rd_data, prev);
    cfg_write(mk(1'b1, 0, 3, 3));
    chk("R9", "wen=3 kept", cfg_rd_data, prev);
    cfg_write(mk(1'b1, 0, 1, 4));
    chk("R9", "legal after err", cfg_rd_data, mk(1'b1, 0, 1, 4));
    chk("R9", "err sticky", 16'(cfg_err), 16'd1);
    req_valid = 1'b1; req_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    watch_cycle(0, 1, 4, 1'b0);
  endtask

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sync();
    t_readback();
    t_async(1, 3, 29, 1'b0);
    t_async(0, 7, 12, 1'b1);
    t_async(3, 7, 31, 1'b0);
    t_async(2, 5, 20, 1'b1);
    t_ignored_req();
    t_held_write();
    t_illegal();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule